// File: doc/BRIEF.md
# Preamble Bit-Check Validator

This block decides, during each polling wake-up window, whether a genuine transmitter is on the air or whether the demodulator is only producing noise. After a wake request it spends a fixed start-up period. It then enters a check phase in which it watches a single demodulated bit. The bit is sampled only on a slow tick that an external divider supplies. An interval counter measures the number of ticks between successive edges of the sampled bit, and each interval is scored against a programmable lower and upper limit.

A run of valid intervals of the required length moves the block into receive mode, where it stays until software explicitly returns it to polling. Any interval that is too short, or that stretches to the upper limit, ends the window at once and sends the block back to sleep. One-cycle pulses announce success and failure. A 2-bit mode output reports the current phase.

Top module: `preamble_check`

## Requirements
- R1: After reset, `mode` reads sleep (encoding 0) and both `okPulse` and `failPulse` are low.
- R2: A `wakeStart` pulse moves the block from sleep to start-up (encoding 1). `wakeStart` has no effect in any other mode, and the block stays in sleep without it.
- R3: Start-up lasts exactly STARTUP_TICKS ticks (default 7). On the last of them the mode becomes check (encoding 2).
- R4: The demodulated input is sampled, and the interval counter advances, only in cycles with `tickEn` high. Any number of cycles without a tick leaves the check phase unchanged.
- R5: On entry to check, the counter is 1. The first edge seen in check only arms the scoring: it restarts the counter at 1 and is never scored. Every later edge also restarts the counter at 1.
- R6: An edge after arming that arrives while the counter is below `limMin` fails the check. `failPulse` is raised and the mode returns to sleep.
- R7: A tick without an edge that would bring the counter to `limMax` fails the check. This applies both before and after arming. For example, with limits 14/24, an edge-free tick 23 ticks after the last edge fails.
- R8: An edge after arming with the counter at or above `limMin` is a valid interval. When the number of consecutive valid intervals reaches `bitNeed` (a value of 0 acts as 1), `okPulse` is raised and the mode becomes receive (encoding 3).
- R9: `okPulse` and `failPulse` last one cycle and never coincide. Each appears in the same cycle as the corresponding mode change.
- R10: Receive mode holds regardless of input edges, ticks or `wakeStart` until `pollCmd`, which returns the block to sleep. `pollCmd` has no effect in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle slow sampling tick |
| demodIn | input | 1 | Demodulated data bit, synchronous to clk |
| wakeStart | input | 1 | Starts a polling window from sleep |
| pollCmd | input | 1 | Returns the block from receive to sleep |
| limMin | input | CNT_W | Lowest counter value accepted for an interval |
| limMax | input | CNT_W | Counter value at which an interval times out |
| bitNeed | input | BIT_W | Number of consecutive valid intervals required |
| mode | output | 2 | 0 sleep, 1 start-up, 2 check, 3 receive |
| okPulse | output | 1 | One-cycle pulse on successful check |
| failPulse | output | 1 | One-cycle pulse on failed check |

## Verification
A corrupted interval count shows up at the ports on the very tick that scores the interval. An off-by-one in the counter moves a boundary interval (exactly `limMin`, or `limMax`−1 ticks) between success and failure, so the outcome pulse lands on a different interval or with the wrong polarity. A stale armed flag or valid-interval count shifts the interval index at which `okPulse` appears by one. A wrong state register is visible in `mode` one cycle after the event that should, or should not, have moved it.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_START = 2'd1,
    MODE_CHECK = 2'd2,
    MODE_RECV  = 2'd3
  } pbcMode_e;

  // control -> datapath
  typedef struct packed {
    logic startClr;
    logic startRun;
    logic checkClr;
    logic checkRun;
  } pbcStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic startDone;
    logic failNow;
    logic passDone;
  } pbcStatus_t;

endpackage

// File: rtl/pbc_datapath.sv
module pbc_datapath
  import pbc_pkg::*;
#(
  parameter int CNT_W         = 6,
  parameter int BIT_W         = 4,
  parameter int STARTUP_TICKS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             demodIn,
  input  logic [CNT_W-1:0] limMin,
  input  logic [CNT_W-1:0] limMax,
  input  logic [BIT_W-1:0] bitNeed,
  input  pbcStrobe_t       strb,
  output pbcStatus_t       stat
);

  localparam int ST_W = (STARTUP_TICKS > 1) ? $clog2(STARTUP_TICKS) : 1;
  localparam logic [ST_W-1:0]  ST_LAST = ST_W'(STARTUP_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [BIT_W-1:0] GOOD_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             prevSample;
  logic             edgeSeen;
  logic [ST_W-1:0]  startCnt;
  logic [CNT_W-1:0] intCnt;
  logic [CNT_W:0]   intCntInc;
  logic [BIT_W:0]   goodInc;
  logic [BIT_W-1:0] goodCnt;
  logic             armed;
  logic             goodEdge;
  logic             shortEdge;
  logic             timeOut;

  // sampler: demodulated bit is only looked at on a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevSample <= 1'b0;
    else if (tickEn) prevSample <= demodIn;
  end

  assign edgeSeen = tickEn && (demodIn != prevSample);

  // start-up tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          startCnt <= '0;
    else if (strb.startClr)             startCnt <= '0;
    else if (strb.startRun && tickEn)   startCnt <= startCnt + 1'b1;
  end

  // interval counter, restarts at one on every edge, saturates at top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 intCnt <= CNT_ONE;
    else if (strb.checkClr)    intCnt <= CNT_ONE;
    else if (strb.checkRun && tickEn) begin
      if (edgeSeen)            intCnt <= CNT_ONE;
      else if (intCnt != CNT_TOP) intCnt <= intCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          armed <= 1'b0;
    else if (strb.checkClr)             armed <= 1'b0;
    else if (strb.checkRun && edgeSeen) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            goodCnt <= '0;
    else if (strb.checkClr)               goodCnt <= '0;
    else if (goodEdge && goodCnt != GOOD_TOP) goodCnt <= goodCnt + 1'b1;
  end

  always_comb begin
    intCntInc = {1'b0, intCnt} + 1'b1;
    goodInc   = {1'b0, goodCnt} + 1'b1;
    goodEdge  = strb.checkRun && edgeSeen && armed && (intCnt >= limMin);
    shortEdge = strb.checkRun && edgeSeen && armed && (intCnt < limMin);
    timeOut   = strb.checkRun && tickEn && !edgeSeen && (intCntInc >= {1'b0, limMax});
  end

  always_comb begin
    stat.startDone = strb.startRun && tickEn && (startCnt == ST_LAST);
    stat.failNow   = shortEdge || timeOut;
    stat.passDone  = goodEdge && (goodInc >= {1'b0, bitNeed});
  end

endmodule

// File: rtl/pbc_control.sv
module pbc_control
  import pbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeStart,
  input  logic       pollCmd,
  input  pbcStatus_t stat,
  output pbcStrobe_t strb,
  output pbcMode_e   state,
  output logic       okPulse,
  output logic       failPulse
);

  pbcMode_e nextState;
  logic     okNext;
  logic     failNext;

  always_comb begin
    nextState     = state;
    okNext        = 1'b0;
    failNext      = 1'b0;
    strb.startRun = (state == MODE_START);
    strb.startClr = (state != MODE_START);
    strb.checkRun = (state == MODE_CHECK);
    strb.checkClr = (state != MODE_CHECK);
    case (state)
      MODE_SLEEP: if (wakeStart) nextState = MODE_START;
      MODE_START: if (stat.startDone) nextState = MODE_CHECK;
      MODE_CHECK: begin
        if (stat.failNow) begin
          nextState = MODE_SLEEP;
          failNext  = 1'b1;
        end else if (stat.passDone) begin
          nextState = MODE_RECV;
          okNext    = 1'b1;
        end
      end
      MODE_RECV:  if (pollCmd) nextState = MODE_SLEEP;
      default:    nextState = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= MODE_SLEEP;
      okPulse   <= 1'b0;
      failPulse <= 1'b0;
    end else begin
      state     <= nextState;
      okPulse   <= okNext;
      failPulse <= failNext;
    end
  end

endmodule

// File: rtl/preamble_check.sv
module preamble_check
  import pbc_pkg::*;
#(
  parameter int CNT_W         = 6,
  parameter int BIT_W         = 4,
  parameter int STARTUP_TICKS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             demodIn,
  input  logic             wakeStart,
  input  logic             pollCmd,
  input  logic [CNT_W-1:0] limMin,
  input  logic [CNT_W-1:0] limMax,
  input  logic [BIT_W-1:0] bitNeed,
  output logic [1:0]       mode,
  output logic             okPulse,
  output logic             failPulse
);

  pbcStrobe_t strb;
  pbcStatus_t stat;
  pbcMode_e   state;

  pbc_datapath #(
    .CNT_W(CNT_W), .BIT_W(BIT_W), .STARTUP_TICKS(STARTUP_TICKS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .demodIn(demodIn),
    .limMin(limMin), .limMax(limMax), .bitNeed(bitNeed),
    .strb(strb), .stat(stat)
  );

  pbc_control ctl_i (
    .clk(clk), .rstN(rstN), .wakeStart(wakeStart), .pollCmd(pollCmd),
    .stat(stat), .strb(strb), .state(state),
    .okPulse(okPulse), .failPulse(failPulse)
  );

  assign mode = state;

endmodule

// File: rtl/preamble_check_sva.sv
module preamble_check_sva (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       wakeStart,
  input logic       pollCmd,
  input logic [1:0] mode,
  input logic       okPulse,
  input logic       failPulse
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(okPulse && failPulse)); // R9
  AST_OK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    okPulse |=> !okPulse); // R9
  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> !failPulse); // R9
  AST_FAIL_TO_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) ##1 failPulse |-> (mode == 2'd0)); // R6
  AST_OK_TO_RECV: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) ##1 okPulse |-> (mode == 2'd3)); // R8
  AST_RECV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && !pollCmd) |=> (mode == 2'd3)); // R10
  AST_RECV_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && pollCmd) |=> (mode == 2'd0)); // R10
  AST_SLEEP_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && !wakeStart) |=> (mode == 2'd0)); // R2
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |=> (mode == 2'd1 || mode == 2'd2)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && !tickEn) |=> (mode == 2'd2)); // R4

endmodule

bind preamble_check preamble_check_sva sva_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wakeStart(wakeStart),
  .pollCmd(pollCmd), .mode(mode), .okPulse(okPulse), .failPulse(failPulse)
);

// File: tb/preamble_check_tb_top.sv
`timescale 1ns/1ps
module preamble_check_tb_top;

  localparam int CNT_W = 6;
  localparam int BIT_W = 4;
  localparam int STARTUP_TICKS = 7;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [7:0]      lo;
    logic [7:0]      hi;
    logic [7:0]      need;
    logic [7:0]      n;
    logic [5:0][7:0] iv;   // iv[0] is the first scored interval
    logic            expOk;
    logic [7:0]      expIdx;
    logic [7:0]      kind; // requirement number checked
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'd14, 8'd24, 8'd4, 8'd4, {8'd0, 8'd0, 8'd16, 8'd16, 8'd16, 8'd16}, 1'b1, 8'd3, 8'd8},
    '{8'd14, 8'd24, 8'd4, 8'd2, {8'd0, 8'd0, 8'd0,  8'd0,  8'd13, 8'd16}, 1'b0, 8'd1, 8'd6},
    '{8'd14, 8'd24, 8'd4, 8'd2, {8'd0, 8'd0, 8'd0,  8'd0,  8'd30, 8'd16}, 1'b0, 8'd1, 8'd7},
    '{8'd14, 8'd24, 8'd3, 8'd3, {8'd0, 8'd0, 8'd0,  8'd14, 8'd23, 8'd14}, 1'b1, 8'd2, 8'd8},
    '{8'd14, 8'd24, 8'd2, 8'd1, {8'd0, 8'd0, 8'd0,  8'd0,  8'd0,  8'd24}, 1'b0, 8'd0, 8'd7},
    '{8'd5,  8'd8,  8'd2, 8'd2, {8'd0, 8'd0, 8'd0,  8'd0,  8'd7,  8'd5},  1'b1, 8'd1, 8'd8},
    '{8'd5,  8'd8,  8'd5, 8'd3, {8'd0, 8'd0, 8'd0,  8'd4,  8'd6,  8'd6},  1'b0, 8'd2, 8'd6},
    '{8'd14, 8'd24, 8'd0, 8'd1, {8'd0, 8'd0, 8'd0,  8'd0,  8'd0,  8'd15}, 1'b1, 8'd0, 8'd8},
    '{8'd10, 8'd12, 8'd6, 8'd6, {8'd11, 8'd10, 8'd11, 8'd10, 8'd11, 8'd11}, 1'b1, 8'd5, 8'd8},
    '{8'd14, 8'd24, 8'd4, 8'd3, {8'd0, 8'd0, 8'd0,  8'd25, 8'd16, 8'd16}, 1'b0, 8'd2, 8'd7}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic demodIn = 1'b0;
  logic wakeStart = 1'b0;
  logic pollCmd = 1'b0;
  logic [CNT_W-1:0] limMin = 6'd14;
  logic [CNT_W-1:0] limMax = 6'd24;
  logic [BIT_W-1:0] bitNeed = 4'd4;
  logic [1:0] mode;
  logic okPulse, failPulse;

  logic sawOk, sawFail;
  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  preamble_check #(.CNT_W(CNT_W), .BIT_W(BIT_W), .STARTUP_TICKS(STARTUP_TICKS)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .demodIn(demodIn),
    .wakeStart(wakeStart), .pollCmd(pollCmd),
    .limMin(limMin), .limMax(limMax), .bitNeed(bitNeed),
    .mode(mode), .okPulse(okPulse), .failPulse(failPulse)
  );

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    nChecks++;
    if (!good) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // one tick with the given input level; outputs captured just after the edge
  task automatic tick(input logic d);
    @(negedge clk);
    demodIn = d;
    tickEn  = 1'b1;
    @(negedge clk);
    tickEn  = 1'b0;
    sawOk   = okPulse;
    sawFail = failPulse;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeStart = 1'b1;
    @(negedge clk); wakeStart = 1'b0;
  endtask

  task automatic pulsePoll();
    @(negedge clk); pollCmd = 1'b1;
    @(negedge clk); pollCmd = 1'b0;
  endtask

  task automatic enterCheck();
    pulseWake();
    for (int i = 0; i < STARTUP_TICKS; i++) tick(demodIn);
  endtask

  task automatic runVec(input int v);
    vec_t t;
    int gotIdx;
    logic gotOk;
    string tag;
    t = VECS[v];
    gotIdx = -1;
    gotOk = 1'b0;
    case (t.kind)
      8'd6:    tag = "R6";
      8'd7:    tag = "R7";
      default: tag = "R8";
    endcase
    if (mode == 2'd3) pulsePoll();
    limMin  = t.lo[CNT_W-1:0];
    limMax  = t.hi[CNT_W-1:0];
    bitNeed = t.need[BIT_W-1:0];
    enterCheck();
    chk(mode == 2'd2, "R3 vector entry", mode, 2);
    tick(~demodIn);  // arming edge
    chk(mode == 2'd2 && !sawOk && !sawFail, "R5 arming edge not scored", mode, 2);
    for (int k = 0; k < int'(t.n) && gotIdx < 0; k++) begin
      for (int j = 1; j <= int'(t.iv[k]) && gotIdx < 0; j++) begin
        tick((j == int'(t.iv[k])) ? ~demodIn : demodIn);
        if (sawOk || sawFail) begin
          gotIdx = k;
          gotOk  = sawOk;
        end
      end
    end
    chk(gotIdx == int'(t.expIdx), {tag, " outcome interval"}, gotIdx, t.expIdx);
    chk(gotOk == t.expOk, {tag, " outcome polarity"}, gotOk, t.expOk);
    chk(mode == (t.expOk ? 2'd3 : 2'd0), {tag, " final mode"}, mode, t.expOk ? 3 : 0);
  endtask

  initial begin
    #1_500_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mode == 2'd0 && !okPulse && !failPulse, "R1 reset state", mode, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(mode == 2'd0 && !okPulse && !failPulse, "R1 after release", mode, 0);

    for (int v = 0; v < NVEC; v++) runVec(v);
    if (mode == 2'd3) pulsePoll();

    // R2: no wake request, ticks alone keep sleep
    for (int i = 0; i < 3; i++) tick(~demodIn);
    chk(mode == 2'd0, "R2 sleep holds without wake", mode, 0);

    // R3: start-up length
    limMin = 6'd14; limMax = 6'd24; bitNeed = 4'd2;
    pulseWake();
    chk(mode == 2'd1, "R2 wake enters start-up", mode, 1);
    for (int i = 0; i < STARTUP_TICKS - 1; i++) tick(demodIn);
    chk(mode == 2'd1, "R3 start-up before last tick", mode, 1);
    tick(demodIn);
    chk(mode == 2'd2, "R3 check after last tick", mode, 2);

    // R4: arm, then long stretch of clocks without ticks
    tick(~demodIn);
    for (int i = 0; i < 10; i++) tick(demodIn);
    repeat (300) @(negedge clk);
    chk(mode == 2'd2 && !failPulse, "R4 no tick no timeout", mode, 2);

    // R10 / R2: commands ignored during check
    pulsePoll();
    pulseWake();
    chk(mode == 2'd2, "R10 poll ignored in check", mode, 2);
    // 10 ticks elapsed so far; 5 more and an edge make interval 16
    for (int i = 0; i < 5; i++) tick(demodIn);
    tick(~demodIn);
    chk(mode == 2'd2 && !sawOk, "R8 first valid interval", mode, 2);
    for (int i = 0; i < 14; i++) tick(demodIn);
    tick(~demodIn);
    chk(sawOk && mode == 2'd3, "R8 success after bitNeed intervals", mode, 3);
    chk(!okPulse, "R9 ok pulse lasts one cycle", okPulse, 0);

    // R10: receive holds through timeouts, edges and wake
    for (int i = 0; i < 30; i++) tick(demodIn);
    tick(~demodIn);
    tick(~demodIn);
    pulseWake();
    chk(mode == 2'd3 && !failPulse, "R10 receive holds", mode, 3);
    pulsePoll();
    chk(mode == 2'd0, "R10 poll returns to sleep", mode, 0);

    // R9: fail pulse single cycle
    limMin = 6'd5; limMax = 6'd8; bitNeed = 4'd3;
    enterCheck();
    tick(~demodIn);
    tick(~demodIn);
    chk(sawFail && mode == 2'd0, "R6 short interval fails", mode, 0);
    chk(!failPulse, "R9 fail pulse lasts one cycle", failPulse, 0);

    // R7: timeout before arming
    enterCheck();
    for (int i = 0; i < 7; i++) tick(demodIn);
    chk(sawFail && mode == 2'd0, "R7 timeout before arming", mode, 0);

    finishRun();
  end

endmodule